// File: doc/BRIEF.md
# Multi-Bank Chip-Select Address Decoder

This block sits between a bus master and a set of external memory devices. It holds a table of twelve banks. Each bank has a configuration word that gives a base address, a valid bit, a port width, a memory-machine type and a write-protect bit. A second word gives the address mask. On every bus request the decoder compares the address against all banks at once. One cycle later it drives a one-hot chip select together with the winning bank's port width and machine type. Downstream timing engines use these outputs to run the actual memory cycle.

Software programs the table through a simple register port. The same port reads back the table, the error status and the captured error address. A write that lands on a write-protected bank never reaches memory. Instead it raises a one-cycle fault pulse and sets a sticky status flag. The faulting address is stored if no earlier error is still pending. Software clears the flag by writing a one to it.

Top module: `cs_decoder`

## Requirements
- R1: There are NUM_BANKS (default 12) banks. Register index 2*i holds bank i's configuration word, index 2*i+1 holds its mask word, index 2*NUM_BANKS (24) is the status word, and index 2*NUM_BANKS+1 (25) is the read-only error address.
- R2: Bank i matches an address when (addr & mask) equals (base & mask), both taken over bits 31:15. The base is configuration bits 31:15 and the mask is mask-word bits 31:15.
- R3: Configuration bit 0 is the valid bit. A bank whose valid bit is clear never matches.
- R4: When several banks match, the bank with the lowest index is selected.
- R5: In the cycle after an accepted access, `port_size_o` carries configuration bits 12:11 (01 = 8-bit, 10 = 16-bit, 11 = 32-bit) and `mach_sel_o` carries bits 7:5 (000 general-purpose, 001 flash, 011 SDRAM, 100/101/110 programmable A/B/C). `hit_o` is 1 in that cycle.
- R6: `cs_o` is one-hot (bit i for bank i), registered, and valid in the cycle after `bus_req` is sampled high. With `bus_req` low, or with no bank matching, the next cycle shows `cs_o`, `hit_o`, `port_size_o` and `mach_sel_o` all zero.
- R7: Configuration bit 8 is write-protect. A write (`bus_wr`=1) whose selected bank is protected gives no chip select and `hit_o`=0, and `wp_fault_o`=1 for one cycle. It also sets status bit 26 (`err_flag_o`). A read of a protected bank is decoded normally.
- R8: On a protected-write fault, the bus address is copied into the error address register only if status bit 26 was clear before the fault.
- R9: Writing the status word with bit 26 set clears the flag. Writing it with bit 26 clear has no effect. If a fault happens in the same cycle as a clear, the flag stays set and the error address keeps its value.
- R10: Reserved bits read as zero. A configuration word reads back only bits 31:15, 12:11, 8, 7:5 and 0. A mask word reads back only bits 31:15.
- R11: After synchronous reset, every bank is invalid with all fields zero, the status flag and error address are zero, and all decode outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| bus_req | input | 1 | Access request, sampled on the clock edge |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 32 | Access address |
| cs_o | output | 12 | One-hot chip select, registered |
| hit_o | output | 1 | A chip select is driven this cycle |
| port_size_o | output | 2 | Port width code of the selected bank |
| mach_sel_o | output | 3 | Machine type code of the selected bank |
| wp_fault_o | output | 1 | One-cycle pulse on a protected write |
| err_flag_o | output | 1 | Sticky write-protect error flag (status bit 26) |

## Verification
The bench places two valid banks over the same address range. It checks that the lower index wins, and that invalidating the winner hands the access to the other bank. A design with a reversed priority chain would select the wrong chip. A design that ignores the valid bit would keep selecting the dead bank. A second protected write is sent while the flag is still set; a decoder without the pending guard would overwrite the first error address. A status clear is issued in the same cycle as a new fault; a design that lets the clear win would lose the error. The bench also checks the readback of all-ones configuration words against the field mask, and it sends a read to a protected bank, which a design that blocks both directions would wrongly refuse.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;

    localparam int ADDR_W      = 32;
    localparam int TAG_LSB     = 15;
    localparam int TAG_W       = ADDR_W - TAG_LSB;
    localparam int WP_FLAG_BIT = 26;

    typedef struct packed {
        logic [TAG_W-1:0] base;
        logic [1:0]       psize;
        logic             wprot;
        logic [2:0]       msel;
        logic             valid;
    } bank_cfg_t;

    function automatic bank_cfg_t cfg_from_word(input logic [ADDR_W-1:0] w);
        bank_cfg_t c;
        c.base  = w[ADDR_W-1:TAG_LSB];
        c.psize = w[12:11];
        c.wprot = w[8];
        c.msel  = w[7:5];
        c.valid = w[0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] word_from_cfg(input bank_cfg_t c);
        logic [ADDR_W-1:0] w;
        w = '0;
        w[ADDR_W-1:TAG_LSB] = c.base;
        w[12:11] = c.psize;
        w[8]     = c.wprot;
        w[7:5]   = c.msel;
        w[0]     = c.valid;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] word_from_mask(input logic [TAG_W-1:0] m);
        return {m, {TAG_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/bank_table.sv
module bank_table
    import cs_decoder_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int IDX_W     = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [ADDR_W-1:0]                  wdata,
    input  logic                               err_flag,
    input  logic [ADDR_W-1:0]                  err_addr,
    output logic [ADDR_W-1:0]                  rdata,
    output bank_cfg_t [NUM_BANKS-1:0]          cfg_q,
    output logic [NUM_BANKS-1:0][TAG_W-1:0]    mask_q
);
    localparam int STATUS_IDX = 2 * NUM_BANKS;
    localparam int ERRA_IDX   = 2 * NUM_BANKS + 1;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i]  <= '0;
                mask_q[i] <= '0;
            end else if (we) begin
                if (idx == IDX_W'(2 * i))
                    cfg_q[i] <= cfg_from_word(wdata);
                if (idx == IDX_W'(2 * i + 1))
                    mask_q[i] <= wdata[ADDR_W-1:TAG_LSB];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (idx == IDX_W'(2 * i))     rdata = word_from_cfg(cfg_q[i]);
            if (idx == IDX_W'(2 * i + 1)) rdata = word_from_mask(mask_q[i]);
        end
        if (idx == IDX_W'(STATUS_IDX)) rdata[WP_FLAG_BIT] = err_flag;
        if (idx == IDX_W'(ERRA_IDX))   rdata = err_addr;
    end

endmodule

// File: rtl/bank_match.sv
module bank_match
    import cs_decoder_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int SEL_W     = 4
) (
    input  bank_cfg_t [NUM_BANKS-1:0]       cfg_q,
    input  logic [NUM_BANKS-1:0][TAG_W-1:0] mask_q,
    input  logic [ADDR_W-1:0]               addr,
    output logic                            any_hit,
    output logic [SEL_W-1:0]                sel
);
    logic [NUM_BANKS-1:0] hit_vec;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
        assign hit_vec[i] = cfg_q[i].valid &&
            ((addr[ADDR_W-1:TAG_LSB] & mask_q[i]) == (cfg_q[i].base & mask_q[i]));
    end

    // Lowest index wins: scan downward so the last hit written is the lowest.
    always_comb begin
        sel = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = SEL_W'(i);
        end
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/wp_error_capture.sv
module wp_error_capture
    import cs_decoder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_set,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              clr_req,
    output logic              flag_q,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            addr_q <= '0;
        end else begin
            if (fault_set) begin
                flag_q <= 1'b1;
                if (!flag_q) addr_q <= fault_addr;
            end else if (clr_req) begin
                flag_q <= 1'b0;
            end
        end
    end

    // R7: a fault always leaves the flag set
    p_fault_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        fault_set |=> flag_q);

    // R9: only a clear request drops the flag
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);

    // R8: a pending error freezes the captured address
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> $stable(addr_q));

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_decoder_pkg::*;
#(
    parameter  int NUM_BANKS = 12,
    localparam int IDX_W     = $clog2(2 * NUM_BANKS + 2),
    localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_addr,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [ADDR_W-1:0]     cfg_rdata,
    input  logic                  bus_req,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic [NUM_BANKS-1:0]  cs_o,
    output logic                  hit_o,
    output logic [1:0]            port_size_o,
    output logic [2:0]            mach_sel_o,
    output logic                  wp_fault_o,
    output logic                  err_flag_o
);
    localparam int STATUS_IDX = 2 * NUM_BANKS;

    bank_cfg_t [NUM_BANKS-1:0]       cfg_q;
    logic [NUM_BANKS-1:0][TAG_W-1:0] mask_q;
    logic                            any_hit;
    logic [SEL_W-1:0]                sel;
    logic                            err_flag;
    logic [ADDR_W-1:0]               err_addr;
    bank_cfg_t                       sel_cfg;
    logic                            fault_d;
    logic                            grant_d;
    logic                            clr_req;

    bank_table #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .idx      (cfg_addr),
        .wdata    (cfg_wdata),
        .err_flag (err_flag),
        .err_addr (err_addr),
        .rdata    (cfg_rdata),
        .cfg_q    (cfg_q),
        .mask_q   (mask_q)
    );

    bank_match #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_match (
        .cfg_q   (cfg_q),
        .mask_q  (mask_q),
        .addr    (bus_addr),
        .any_hit (any_hit),
        .sel     (sel)
    );

    assign sel_cfg = cfg_q[sel];
    assign fault_d = bus_req && any_hit && bus_wr && sel_cfg.wprot;
    assign grant_d = bus_req && any_hit && !fault_d;
    assign clr_req = cfg_we && (cfg_addr == IDX_W'(STATUS_IDX)) && cfg_wdata[WP_FLAG_BIT];

    wp_error_capture u_err (
        .clk        (clk),
        .rst        (rst),
        .fault_set  (fault_d),
        .fault_addr (bus_addr),
        .clr_req    (clr_req),
        .flag_q     (err_flag),
        .addr_q     (err_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_o        <= '0;
            hit_o       <= 1'b0;
            port_size_o <= '0;
            mach_sel_o  <= '0;
            wp_fault_o  <= 1'b0;
        end else begin
            cs_o        <= '0;
            hit_o       <= grant_d;
            port_size_o <= grant_d ? sel_cfg.psize : 2'b00;
            mach_sel_o  <= grant_d ? sel_cfg.msel  : 3'b000;
            wp_fault_o  <= fault_d;
            if (grant_d) cs_o[sel] <= 1'b1;
        end
    end

    assign err_flag_o = err_flag;

    // R6: never more than one chip select
    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_o));

    // R6: no request means no chip select next cycle
    p_idle_no_cs_r6: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> (cs_o == '0));

    // R7: a protected write never drives a chip select
    p_wp_no_cs_r7: assert property (@(posedge clk) disable iff (rst)
        wp_fault_o |-> (cs_o == '0 && !hit_o));

    // R5: the hit flag agrees with the chip-select vector
    p_hit_matches_cs_r5: assert property (@(posedge clk) disable iff (rst)
        hit_o == (cs_o != '0));

endmodule

// File: tb/tb_cs_decoder.sv
module tb_cs_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [11:0] cs_o;
    logic        hit_o;
    logic [1:0]  port_size_o;
    logic [2:0]  mach_sel_o;
    logic        wp_fault_o;
    logic        err_flag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cs_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .cs_o(cs_o), .hit_o(hit_o),
        .port_size_o(port_size_o), .mach_sel_o(mach_sel_o),
        .wp_fault_o(wp_fault_o), .err_flag_o(err_flag_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input int idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] d);
        cfg_addr = 5'(idx);
        #1 d = cfg_rdata;
    endtask

    task automatic access(input logic [31:0] a, input logic wr);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_sel(input string req, input int bank, input logic [1:0] ps,
                              input logic [2:0] ms);
        chk({req, " cs"}, 32'(cs_o), (bank < 0) ? 32'h0 : (32'h1 << bank));
        chk({req, " hit"}, 32'(hit_o), (bank < 0) ? 32'h0 : 32'h1);
        chk({req, " psize"}, 32'(port_size_o), 32'(ps));
        chk({req, " msel"}, 32'(mach_sel_o), 32'(ms));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        expect_sel("R11 reset", -1, 2'b00, 3'b000);
        chk("R11 reset fault", 32'(wp_fault_o), 0);
        chk("R11 reset flag", 32'(err_flag_o), 0);
        reg_rd(0, d);  chk("R11 reset base0", d, 0);
        reg_rd(25, d); chk("R11 reset erraddr", d, 0);
    endtask

    task automatic t_basic_match();
        // bank 0: base 0x1000_0000, 32-bit, general-purpose, valid; 32 KB window
        reg_wr(0, 32'h1000_1801);
        reg_wr(1, 32'hFFFF_8000);
        access(32'h1000_0004, 1'b0);
        expect_sel("R2 R5 bank0 read", 0, 2'b11, 3'b000);
        access(32'h1000_7FFC, 1'b1);
        expect_sel("R2 bank0 window top write", 0, 2'b11, 3'b000);
        access(32'h1000_8000, 1'b0);
        expect_sel("R2 just past window", -1, 2'b00, 3'b000);
        // bank 3: base 0x2000_0000, 8-bit, SDRAM, 256 MB window
        reg_wr(6, 32'h2000_0861);
        reg_wr(7, 32'hF000_0000);
        access(32'h2345_6789, 1'b0);
        expect_sel("R2 R5 bank3 wide mask", 3, 2'b01, 3'b011);
    endtask

    task automatic t_idle();
        bus_addr = 32'h1000_0000; bus_req = 1'b0;
        @(negedge clk);
        expect_sel("R6 no request", -1, 2'b00, 3'b000);
    endtask

    task automatic t_priority();
        // bank 5: base 0x2000_0000, 16-bit, programmable B, 32 KB window
        reg_wr(10, 32'h2000_10A1);
        reg_wr(11, 32'hFFFF_8000);
        access(32'h2000_0010, 1'b0);
        expect_sel("R4 lowest bank wins", 3, 2'b01, 3'b011);
        reg_wr(6, 32'h2000_0860); // clear valid on bank 3
        access(32'h2000_0010, 1'b0);
        expect_sel("R3 R4 invalid bank skipped", 5, 2'b10, 3'b101);
        access(32'h2345_6789, 1'b0);
        expect_sel("R3 invalid bank no match", -1, 2'b00, 3'b000);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        reg_wr(14, 32'hFFFF_FFFF);
        reg_wr(15, 32'hFFFF_FFFF);
        reg_rd(14, d); chk("R10 R1 config reserved zero", d, 32'hFFFF_99E1);
        reg_rd(15, d); chk("R10 R1 mask reserved zero", d, 32'hFFFF_8000);
        reg_rd(10, d); chk("R1 bank5 config readback", d, 32'h2000_10A1);
    endtask

    task automatic t_write_protect();
        logic [31:0] d;
        // bank 7 is valid, protected, 32-bit, code 111, at 0xFFFF_8000
        access(32'hFFFF_8010, 1'b0);
        expect_sel("R7 read of protected bank", 7, 2'b11, 3'b111);
        chk("R7 read no fault", 32'(wp_fault_o), 0);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 32'hFFFF_8010;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        expect_sel("R7 protected write blocked", -1, 2'b00, 3'b000);
        chk("R7 fault pulse", 32'(wp_fault_o), 1);
        chk("R7 flag set", 32'(err_flag_o), 1);
        reg_rd(24, d); chk("R7 status bit 26", d, 32'h0400_0000);
        reg_rd(25, d); chk("R8 first address captured", d, 32'hFFFF_8010);
        @(negedge clk);
        chk("R7 fault is one cycle", 32'(wp_fault_o), 0);
        access(32'hFFFF_8020, 1'b1);
        reg_rd(25, d); chk("R8 pending error keeps address", d, 32'hFFFF_8010);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        reg_wr(24, 32'hFBFF_FFFF);
        chk("R9 write zero keeps flag", 32'(err_flag_o), 1);
        reg_wr(24, 32'h0400_0000);
        chk("R9 write one clears flag", 32'(err_flag_o), 0);
        access(32'hFFFF_8030, 1'b1);
        reg_rd(25, d); chk("R8 new address after clear", d, 32'hFFFF_8030);
        // clear and fault in the same cycle: fault wins
        cfg_we = 1'b1; cfg_addr = 5'd24; cfg_wdata = 32'h0400_0000;
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 32'hFFFF_8040;
        @(negedge clk);
        cfg_we = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
        chk("R9 fault beats clear flag", 32'(err_flag_o), 1);
        reg_rd(25, d); chk("R9 fault beats clear address", d, 32'hFFFF_8030);
        access(32'h1000_0000, 1'b1);
        chk("R7 unprotected write no fault", 32'(wp_fault_o), 0);
        expect_sel("R7 unprotected write granted", 0, 2'b11, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_match();
        t_idle();
        t_priority();
        t_readback();
        t_write_protect();
        t_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule